// File: doc/BRIEF.md
# Fragment Color Combiner Stage

This block is one stage of a fragment colour pipeline working on 8-bit RGBA values. Each fragment arrives as a bundle that carries every candidate colour together with a valid strobe. The candidates are the primary colour, four texture colours, the previous-buffer colour, a constant colour and the result of the previous stage. The stage's configuration arrives with the same bundle. Three source selectors each pick one operand colour. An arithmetic operation then combines the three operands, and it is applied separately to each of the four channels.

The stage has two registers. Operand selection is registered first, and the arithmetic result is registered second. A result therefore appears two cycles after its input, and the valid strobe travels alongside the data. Stages can be chained by feeding one stage's output into the next stage's previous-stage input.

Top module: `frag_combiner_stage`

## Requirements
- R1: A 32-bit colour holds R in bits 7:0, G in 15:8, B in 23:16 and A in 31:24. The source codes select as follows: 0x0 primary colour, 0x3/0x4/0x5/0x6 texture 0/1/2/3 (texture n sits in tex_colors bits 32n+31:32n), 0xD previous-buffer colour, 0xE constant colour, 0xF previous-stage colour.
- R2: Source code 0x1 (primary fragment colour) yields the same value as the primary colour.
- R3: Source code 0x2 (secondary fragment colour) yields all-zero RGBA.
- R4: Source codes 0x7 to 0xC are unused and yield all-zero RGBA.
- R5: Op code 0 (replace) outputs operand A. Op code 1 (modulate) outputs (A·B)/255 with integer division.
- R6: Op code 2 (add) outputs A+B, saturated at 255.
- R7: Op code 3 (signed add) outputs A+B−128, clamped to the range 0 to 255.
- R8: Op code 4 (interpolate) outputs (A·C + B·(255−C))/255 with integer division.
- R9: Op code 5 (subtract) outputs A−B, floored at 0. Op codes 6 and 7 output zero.
- R10: After reset, out_valid is low and out_color is zero. Each input accepted with in_valid high produces exactly one out_valid pulse two cycles later, and back-to-back inputs give back-to-back results.
- R11: While no new result is produced, out_color holds its last value.
- R12: The operation is applied to each channel independently, using only that channel's operand bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input bundle valid |
| prim_color | input | 32 | Primary colour |
| tex_colors | input | 128 | Four texture colours, texture n in bits 32n+31:32n |
| prevbuf_color | input | 32 | Previous-buffer colour |
| const_color | input | 32 | Constant colour |
| prev_color | input | 32 | Previous stage result |
| sel_a | input | 4 | Source code for operand A |
| sel_b | input | 4 | Source code for operand B |
| sel_c | input | 4 | Source code for operand C |
| op | input | 3 | Operation code |
| out_valid | output | 1 | Result valid |
| out_color | output | 32 | Combined RGBA result |

## Verification
The arithmetic is swept over every operation code, with operand bytes drawn from a set that straddles 0, 127/128/129, 254 and 255. This set exposes saturation, the clamp at both ends of the signed add, and the rounding of the divisions by 255. Each channel receives a different rotation of the operand triple, so channels that are crossed or shared show up as mismatches. All 4096 combinations of the three selectors are run under add and under interpolate, with a distinct colour on every source. This separates each source code from the others and from the codes that must yield zero, on each operand position. A burst of consecutive inputs checks that results emerge in order at two cycles of latency. The cycles after each result check that out_valid drops and out_color holds.

// File: rtl/frag_comb_pkg.sv
// Shared encodings for the fragment colour combiner.
// Assumes source codes are 4 bits wide and op codes are 3 bits wide.
package frag_comb_pkg;
    typedef enum logic [3:0] {
        SRC_PRIM    = 4'h0,
        SRC_PFRAG   = 4'h1,
        SRC_SFRAG   = 4'h2,
        SRC_TEX0    = 4'h3,
        SRC_PREVBUF = 4'hD,
        SRC_CONST   = 4'hE,
        SRC_PREV    = 4'hF
    } comb_src_e;

    typedef enum logic [2:0] {
        OP_REPLACE  = 3'd0,
        OP_MODULATE = 3'd1,
        OP_ADD      = 3'd2,
        OP_ADDSIGN  = 3'd3,
        OP_LERP     = 3'd4,
        OP_SUB      = 3'd5
    } comb_op_e;
endpackage

// File: rtl/cc_src_mux.sv
// Picks one operand colour from the candidate sources using a sparse
// 4-bit code. Assumes NTEX <= 4 so the texture codes end below 0x7.
// Unused codes and the secondary fragment slot give zero.
module cc_src_mux
    import frag_comb_pkg::*;
#(
    parameter int CW   = 8,
    parameter int NCH  = 4,
    parameter int NTEX = 4
) (
    input  logic [3:0]           sel,
    input  logic [CW*NCH-1:0]    prim,
    input  logic [NTEX*CW*NCH-1:0] tex,
    input  logic [CW*NCH-1:0]    prevbuf,
    input  logic [CW*NCH-1:0]    konst,
    input  logic [CW*NCH-1:0]    prev,
    output logic [CW*NCH-1:0]    col
);
    localparam int PW = CW * NCH;

    // Decode the source code into the chosen colour.
    always_comb begin
        col = '0;
        if (sel == SRC_PRIM || sel == SRC_PFRAG) col = prim;
        if (sel == SRC_PREVBUF) col = prevbuf;
        if (sel == SRC_CONST)   col = konst;
        if (sel == SRC_PREV)    col = prev;
        for (int t = 0; t < NTEX; t++) begin
            if (sel == 4'(int'(SRC_TEX0) + t)) col = tex[t*PW +: PW];
        end
    end
endmodule

// File: rtl/cc_chan_alu.sv
// Combinational per-channel arithmetic for one colour channel.
// Assumes unsigned CW-bit operands; all results are clamped to CW bits.
module cc_chan_alu
    import frag_comb_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [2:0]    op,
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    input  logic [CW-1:0] c,
    output logic [CW-1:0] y
);
    localparam int WW = 2 * CW + 1;
    localparam logic [WW-1:0] MAXW  = WW'((1 << CW) - 1);
    localparam logic [WW-1:0] BIASW = WW'(1 << (CW - 1));

    logic [WW-1:0] aw, bw, cw_w, sum_w, mul_w, lerp_w, sdiff_w;

    // Widen the operands and form the shared intermediate terms.
    always_comb begin
        aw      = WW'(a);
        bw      = WW'(b);
        cw_w    = WW'(c);
        sum_w   = aw + bw;
        mul_w   = aw * bw;
        lerp_w  = aw * cw_w + bw * (MAXW - cw_w);
        sdiff_w = sum_w - BIASW;
    end

    // Select and clamp the result for the requested operation.
    always_comb begin
        case (op)
            OP_REPLACE:  y = a;
            OP_MODULATE: y = CW'(mul_w / MAXW);
            OP_ADD:      y = (sum_w > MAXW) ? '1 : CW'(sum_w);
            OP_ADDSIGN: begin
                if (sum_w < BIASW)        y = '0;
                else if (sdiff_w > MAXW)  y = '1;
                else                      y = CW'(sdiff_w);
            end
            OP_LERP:     y = CW'(lerp_w / MAXW);
            OP_SUB:      y = (a > b) ? a - b : '0;
            default:     y = '0;
        endcase
    end
endmodule

// File: rtl/frag_combiner_stage.sv
// One combiner stage: operand selection is registered in stage 1, the
// per-channel arithmetic is registered in stage 2. Result latency is
// two cycles; data registers load only on a valid beat, so the output
// holds between results. Synchronous active-low reset.
module frag_combiner_stage
    import frag_comb_pkg::*;
#(
    parameter int CW   = 8,
    parameter int NCH  = 4,
    parameter int NTEX = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [CW*NCH-1:0]      prim_color,
    input  logic [NTEX*CW*NCH-1:0] tex_colors,
    input  logic [CW*NCH-1:0]      prevbuf_color,
    input  logic [CW*NCH-1:0]      const_color,
    input  logic [CW*NCH-1:0]      prev_color,
    input  logic [3:0]             sel_a,
    input  logic [3:0]             sel_b,
    input  logic [3:0]             sel_c,
    input  logic [2:0]             op,
    output logic                   out_valid,
    output logic [CW*NCH-1:0]      out_color
);
    localparam int PW   = CW * NCH;
    localparam int NOPS = 3;

    logic [3:0]    sel_v  [NOPS];
    logic [PW-1:0] pick   [NOPS];
    logic [PW-1:0] s1_opd [NOPS];
    logic [2:0]    s1_op;
    logic          s1_valid;
    logic [PW-1:0] alu_out;

    assign sel_v[0] = sel_a;
    assign sel_v[1] = sel_b;
    assign sel_v[2] = sel_c;

    for (genvar k = 0; k < NOPS; k++) begin : g_sel
        cc_src_mux #(.CW(CW), .NCH(NCH), .NTEX(NTEX)) u_mux (
            .sel     (sel_v[k]),
            .prim    (prim_color),
            .tex     (tex_colors),
            .prevbuf (prevbuf_color),
            .konst   (const_color),
            .prev    (prev_color),
            .col     (pick[k])
        );

        // Stage 1: capture the selected operand on a valid beat.
        always_ff @(posedge clk) begin
            if (!rst_n)        s1_opd[k] <= '0;
            else if (in_valid) s1_opd[k] <= pick[k];
        end
    end

    // Stage 1: carry the valid strobe and capture the op code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_op <= op;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        cc_chan_alu #(.CW(CW)) u_alu (
            .op (s1_op),
            .a  (s1_opd[0][ch*CW +: CW]),
            .b  (s1_opd[1][ch*CW +: CW]),
            .c  (s1_opd[2][ch*CW +: CW]),
            .y  (alu_out[ch*CW +: CW])
        );
    end

    // Stage 2: register the combined colour and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_color <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_color <= alu_out;
        end
    end
endmodule

// File: rtl/frag_combiner_stage_chk.sv
// Assertion checker for frag_combiner_stage, attached by bind.
// Assumes the default 32-bit colour width.
module frag_combiner_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] prim_color,
    input logic [3:0]  sel_a,
    input logic [2:0]  op,
    input logic        out_valid,
    input logic [31:0] out_color
);
    logic [1:0] warm_cnt;
    logic       warm;

    // Count clock edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd2);

    // R10: the strobe follows the input strobe two cycles later.
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)));

    // R11: the colour holds when no new result arrives.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(in_valid, 2)) |-> $stable(out_color));

    // R2: primary fragment code passes the primary colour through replace.
    p_pfrag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 2) && $past(op, 2) == 3'd0 && $past(sel_a, 2) == 4'h1)
        |-> (out_color == $past(prim_color, 2)));

    // R3: secondary fragment code gives zero through replace.
    p_sfrag_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 2) && $past(op, 2) == 3'd0 && $past(sel_a, 2) == 4'h2)
        |-> (out_color == 32'h0));

    // R4: unused codes give zero through replace.
    p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 2) && $past(op, 2) == 3'd0
         && $past(sel_a, 2) >= 4'h7 && $past(sel_a, 2) <= 4'hC)
        |-> (out_color == 32'h0));
endmodule

bind frag_combiner_stage frag_combiner_stage_chk u_chk (.*);

// File: tb/frag_combiner_stage_tb.sv
module frag_combiner_stage_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [31:0]  prim_color, prevbuf_color, const_color, prev_color;
    logic [127:0] tex_colors;
    logic [3:0]   sel_a, sel_b, sel_c;
    logic [2:0]   op;
    logic         out_valid;
    logic [31:0]  out_color;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    frag_combiner_stage u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .prim_color(prim_color), .tex_colors(tex_colors),
        .prevbuf_color(prevbuf_color), .const_color(const_color),
        .prev_color(prev_color), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .op(op), .out_valid(out_valid), .out_color(out_color)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ref_op(input int o, input int a, input int b, input int c);
        int t;
        case (o)
            0: return a;
            1: return (a * b) / 255;
            2: return (a + b > 255) ? 255 : a + b;
            3: begin
                t = a + b - 128;
                if (t < 0) t = 0;
                if (t > 255) t = 255;
                return t;
            end
            4: return (a * c + b * (255 - c)) / 255;
            5: return (a > b) ? a - b : 0;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] ref_src(input int code);
        case (code)
            0, 1: return prim_color;
            3: return tex_colors[31:0];
            4: return tex_colors[63:32];
            5: return tex_colors[95:64];
            6: return tex_colors[127:96];
            13: return prevbuf_color;
            14: return const_color;
            15: return prev_color;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] ref_all();
        logic [31:0] va, vb, vc, r;
        va = ref_src(int'(sel_a));
        vb = ref_src(int'(sel_b));
        vc = ref_src(int'(sel_c));
        for (int ch = 0; ch < 4; ch++)
            r[ch*8 +: 8] = 8'(ref_op(int'(op), int'(va[ch*8 +: 8]), int'(vb[ch*8 +: 8]), int'(vc[ch*8 +: 8])));
        return r;
    endfunction

    // One transaction: pulse valid, check latency, result and hold.
    task automatic run_one(input string req);
        logic [31:0] exp;
        @(negedge clk);
        in_valid = 1'b1;
        exp = ref_all();
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R10 early", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        check(out_valid == 1'b1, "R10 valid", {31'b0, out_valid}, 32'h1);
        check(out_color == exp, req, out_color, exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 single pulse", {31'b0, out_valid}, 32'h0);
        check(out_color == exp, "R11 hold", out_color, exp);
    endtask

    function automatic string src_tag(input int code);
        if (code == 1) return "R2 pfrag";
        if (code == 2) return "R3 sfrag";
        if (code >= 7 && code <= 12) return "R4 unused";
        return "R1 source";
    endfunction

    function automatic string op_tag(input int o);
        case (o)
            0, 1: return "R5 R12 replace/modulate";
            2: return "R6 R12 add";
            3: return "R7 R12 signed add";
            4: return "R8 R12 lerp";
            default: return "R9 R12 sub/zero";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int vals [8] = '{0, 1, 127, 128, 129, 200, 254, 255};
        logic [31:0] burst [3] = '{32'h0102_0304, 32'hF0E0_D0C0, 32'h5A5A_A5A5};
        rst_n = 1'b0; in_valid = 1'b0;
        prim_color = 32'hA13C_7F05; prevbuf_color = 32'h6E2D_91B8;
        const_color = 32'h17F4_4C83; prev_color = 32'hC8_5B_0E_E2;
        tex_colors = {32'h9B06_E1_3A, 32'h2F_A8_55_D7, 32'h80_13_C6_4E, 32'h3D_FF_00_92};
        sel_a = 4'h0; sel_b = 4'h0; sel_c = 4'h0; op = 3'd0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_color == 32'h0, "R10 in reset", out_color, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_color == 32'h0, "R10 after reset", out_color, 32'h0);

        // Source-select sweep on all three operand positions.
        for (int o = 2; o <= 4; o += 2)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    for (int z = 0; z < 16; z++) begin
                        op = 3'(o); sel_a = 4'(x); sel_b = 4'(y); sel_c = 4'(z);
                        run_one(src_tag(x));
                    end

        // Arithmetic sweep: tex0/1/2 as A/B/C, rotated per channel.
        sel_a = 4'h3; sel_b = 4'h4; sel_c = 4'h5;
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int k = 0; k < 8; k++) begin
                        logic [7:0] a, b, c;
                        a = 8'(vals[i]); b = 8'(vals[j]); c = 8'(vals[k]);
                        op = 3'(o);
                        tex_colors[31:0]  = {~a, c, b, a};
                        tex_colors[63:32] = {b, a, c, b};
                        tex_colors[95:64] = {~c, b, a, c};
                        run_one(op_tag(o));
                    end

        // Back-to-back burst: results in order at two cycles.
        op = 3'd0; sel_a = 4'hE;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check(out_valid == 1'b1, "R10 burst valid", {31'b0, out_valid}, 32'h1);
                check(out_color == burst[i-2], "R10 burst order", out_color, burst[i-2]);
            end
            if (i < 3) begin
                const_color = burst[i];
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R10 burst end", {31'b0, out_valid}, 32'h0);
        check(out_color == burst[2], "R11 hold after burst", out_color, burst[2]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule